// File: doc/BRIEF.md
# Capture/Compare Timer with Two-Step Flag Clearing

A 16-bit free-running timer that sits on a byte-wide register bus. The counter either advances once per system clock or follows one chosen edge of an external clock pin. Two capture channels copy the counter when their input pin shows the chosen edge. Two compare channels flag the moment the counter takes the value held in their compare register. An overflow flag marks the counter wrapping from its top value back to zero. All five flags are read together from one read-only status byte.

A flag never clears on a single access. Software first reads the status byte and then reads or writes the low byte that belongs to that flag. The status read only makes clearable those flags that were already set when it happened, so a flag raised between the two accesses survives. A second, alias view of the counter lets software sample the count without disturbing the overflow flag.

External pins pass through a two-stage synchroniser before edge detection. The bus is a plain strobe interface: one cycle of `bus_rd_i` or `bus_wr_i` with an address. Read data is combinational from the registers.

Top module: `cct_timer`

## Requirements
- R1: After reset the status byte reads 00h, the control byte reads 00h, the counter and both capture registers read 0000h, and both compare registers read FFFFh.
- R2: With control bit 3 set, the counter advances by exactly one every clock cycle, wrapping modulo 2^16.
- R3: With control bit 3 clear, the counter advances by one only on the external-clock pin edge chosen by control bit 0 (1 = rising, 0 = falling), seen after the two-stage synchroniser. The other edge, or a static pin, leaves the count unchanged.
- R4: Status bit 5 (overflow) sets when the counter steps from FFFFh to 0000h.
- R5: Overflow clears when a status read (address 0) is followed by a read or write of the counter low byte (address 3). A read of the alias low byte (address 5) leaves it set.
- R6: Status bit 6 (compare 1) and bit 3 (compare 2) set in the cycle the counter steps to a value equal to compare register 1 (bytes at addresses 10 high / 11 low) or compare register 2 (12 / 13). Each clears by a status read followed by an access to its own low byte.
- R7: Capture channel 1 (pin `cap1_i`, edge chosen by control bit 2) and channel 2 (`cap2_i`, control bit 1) use the encoding 1 = rising and 0 = falling. On the chosen edge the channel copies the counter into its capture register (1: addresses 6/7, 2: addresses 8/9) and sets status bit 7 or bit 4. The opposite edge does nothing. Each flag clears by a status read followed by an access to that channel's low byte.
- R8: A low-byte access clears a flag only if that flag was set at the last status read. A flag set after the status read, or accessed with no status read before it, stays set. Flags never fall without a bus access.
- R9: The status byte cannot be written, and its bits 2..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Register address |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| ext_clk_i | input | 1 | External count clock pin |
| cap1_i | input | 1 | Capture channel 1 pin |
| cap2_i | input | 1 | Capture channel 2 pin |

## Verification
The hardest case to reach is a flag that becomes set between the status read and the clearing access, because the bus sequence itself takes cycles. The bench freezes the counter by selecting the external clock with the pin held still. It then reads status while a capture flag is clear, raises the capture pin, and only then accesses the low byte, so the event lands exactly inside the window. Overflow needs a real wrap. The counter is run on the system clock for more than 65,536 cycles and then frozen again, so the clearing sequence can be played out on a still count.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CNT_W  = 2 * BUS_W;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned N_CHAN = 2;
  localparam int unsigned N_FLAG = 5;
  localparam int unsigned PAD_W  = BUS_W - N_FLAG;

  // register addresses
  typedef enum logic [ADDR_W-1:0] {
    A_STAT    = 4'd0,
    A_CTRL    = 4'd1,
    A_CNT_HI  = 4'd2,
    A_CNT_LO  = 4'd3,
    A_ALT_HI  = 4'd4,
    A_ALT_LO  = 4'd5,
    A_CAP1_HI = 4'd6,
    A_CAP1_LO = 4'd7,
    A_CAP2_HI = 4'd8,
    A_CAP2_LO = 4'd9,
    A_CMP1_HI = 4'd10,
    A_CMP1_LO = 4'd11,
    A_CMP2_HI = 4'd12,
    A_CMP2_LO = 4'd13
  } cct_addr_e;

  // flag vector index; status byte = {flags, pad}
  localparam int unsigned FL_OC2 = 0;
  localparam int unsigned FL_IC2 = 1;
  localparam int unsigned FL_TOV = 2;
  localparam int unsigned FL_OC1 = 3;
  localparam int unsigned FL_IC1 = 4;

  // control bits
  localparam int unsigned CTL_EXT_RISE  = 0;
  localparam int unsigned CTL_CAP2_RISE = 1;
  localparam int unsigned CTL_CAP1_RISE = 2;
  localparam int unsigned CTL_INT_CLK   = 3;
endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;
  logic              lvl;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    lvl    = sync_q[STAGES-1];
    last_d = lvl;
    edge_o = rise_sel_i ? (lvl & ~last_q) : (~lvl & last_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_sel_i,
  input  logic             ext_evt_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             tick_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  always_comb begin
    tick   = int_sel_i | ext_evt_i;
    cnt_d  = tick ? cnt_q + 1'b1 : cnt_q;
    wrap_o = tick & (&cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;
  assign tick_o  = tick;
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CMP_RST    = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_pin_i,
  input  logic             cap_rise_i,
  input  logic [CNT_W-1:0] cnt_q_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic             cnt_tick_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             cap_evt_o,
  output logic             cmp_evt_o
);
  logic [CNT_W-1:0] cap_q, cap_d, cmp_q, cmp_d;
  logic             cap_evt;

  cct_edge_det #(.STAGES(SYNC_STAGES)) u_cap_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (cap_pin_i),
    .rise_sel_i (cap_rise_i),
    .edge_o     (cap_evt)
  );

  always_comb begin
    cap_d = cap_evt ? cnt_q_i : cap_q;
    cmp_d = cmp_q;
    if (wr_hi_i) cmp_d[CNT_W-1:BUS_W] = wdata_i;
    if (wr_lo_i) cmp_d[BUS_W-1:0]     = wdata_i;
    cmp_evt_o = cnt_tick_i & (cnt_d_i == cmp_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      cmp_q <= CMP_RST;
    end else begin
      cap_q <= cap_d;
      cmp_q <= cmp_d;
    end
  end

  assign cap_o     = cap_q;
  assign cmp_o     = cmp_q;
  assign cap_evt_o = cap_evt;
endmodule

// File: rtl/cct_flag.sv
module cct_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic arm_i,
  input  logic acc_i,
  output logic flag_o
);
  logic flag_q, flag_d, arm_q, arm_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~(arm_q & acc_i));
    arm_d  = arm_i ? flag_q : (arm_q & ~acc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CMP_RST     = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              ext_clk_i,
  input  logic              cap1_i,
  input  logic              cap2_i
);
  cct_addr_e          addr;
  logic               acc_any, stat_rd;
  logic [CTL_W-1:0]   ctrl_q, ctrl_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cnt_tick, cnt_wrap, ext_evt;
  logic [CNT_W-1:0]   cap_q [N_CHAN];
  logic [CNT_W-1:0]   cmp_q [N_CHAN];
  logic [N_CHAN-1:0]  cap_evt, cmp_evt, cap_pin, cap_rise;
  logic [N_FLAG-1:0]  flag_set, flag_acc, flag_q;

  always_comb begin
    addr    = cct_addr_e'(bus_addr_i);
    acc_any = bus_rd_i | bus_wr_i;
    stat_rd = bus_rd_i & (addr == A_STAT);
    ctrl_d  = (bus_wr_i && addr == A_CTRL) ? bus_wdata_i[CTL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  // external clock edge, used only when the internal clock is not selected
  logic ext_edge;
  cct_edge_det #(.STAGES(SYNC_STAGES)) u_ext_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_clk_i),
    .rise_sel_i (ctrl_q[CTL_EXT_RISE]),
    .edge_o     (ext_edge)
  );
  assign ext_evt = ext_edge & ~ctrl_q[CTL_INT_CLK];

  cct_counter u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_sel_i (ctrl_q[CTL_INT_CLK]),
    .ext_evt_i (ext_evt),
    .cnt_q_o   (cnt_q),
    .cnt_d_o   (cnt_d),
    .tick_o    (cnt_tick),
    .wrap_o    (cnt_wrap)
  );

  assign cap_pin  = {cap2_i, cap1_i};
  assign cap_rise = {ctrl_q[CTL_CAP2_RISE], ctrl_q[CTL_CAP1_RISE]};

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    localparam cct_addr_e CMP_HI_A = (ch == 0) ? A_CMP1_HI : A_CMP2_HI;
    localparam cct_addr_e CMP_LO_A = (ch == 0) ? A_CMP1_LO : A_CMP2_LO;
    logic wr_hi, wr_lo;
    assign wr_hi = bus_wr_i & (addr == CMP_HI_A);
    assign wr_lo = bus_wr_i & (addr == CMP_LO_A);

    cct_channel #(.SYNC_STAGES(SYNC_STAGES), .CMP_RST(CMP_RST)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_pin_i  (cap_pin[ch]),
      .cap_rise_i (cap_rise[ch]),
      .cnt_q_i    (cnt_q),
      .cnt_d_i    (cnt_d),
      .cnt_tick_i (cnt_tick),
      .wr_hi_i    (wr_hi),
      .wr_lo_i    (wr_lo),
      .wdata_i    (bus_wdata_i),
      .cap_o      (cap_q[ch]),
      .cmp_o      (cmp_q[ch]),
      .cap_evt_o  (cap_evt[ch]),
      .cmp_evt_o  (cmp_evt[ch])
    );
  end

  always_comb begin
    flag_set         = '0;
    flag_set[FL_IC1] = cap_evt[0];
    flag_set[FL_OC1] = cmp_evt[0];
    flag_set[FL_TOV] = cnt_wrap;
    flag_set[FL_IC2] = cap_evt[1];
    flag_set[FL_OC2] = cmp_evt[1];
    flag_acc         = '0;
    flag_acc[FL_IC1] = acc_any & (addr == A_CAP1_LO);
    flag_acc[FL_OC1] = acc_any & (addr == A_CMP1_LO);
    flag_acc[FL_TOV] = acc_any & (addr == A_CNT_LO);
    flag_acc[FL_IC2] = acc_any & (addr == A_CAP2_LO);
    flag_acc[FL_OC2] = acc_any & (addr == A_CMP2_LO);
  end

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    cct_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[f]),
      .arm_i  (stat_rd),
      .acc_i  (flag_acc[f]),
      .flag_o (flag_q[f])
    );
  end

  always_comb begin
    case (addr)
      A_STAT:    bus_rdata_o = {flag_q, PAD_W'(0)};
      A_CTRL:    bus_rdata_o = BUS_W'(ctrl_q);
      A_CNT_HI,
      A_ALT_HI:  bus_rdata_o = cnt_q[CNT_W-1:BUS_W];
      A_CNT_LO,
      A_ALT_LO:  bus_rdata_o = cnt_q[BUS_W-1:0];
      A_CAP1_HI: bus_rdata_o = cap_q[0][CNT_W-1:BUS_W];
      A_CAP1_LO: bus_rdata_o = cap_q[0][BUS_W-1:0];
      A_CAP2_HI: bus_rdata_o = cap_q[1][CNT_W-1:BUS_W];
      A_CAP2_LO: bus_rdata_o = cap_q[1][BUS_W-1:0];
      A_CMP1_HI: bus_rdata_o = cmp_q[0][CNT_W-1:BUS_W];
      A_CMP1_LO: bus_rdata_o = cmp_q[0][BUS_W-1:0];
      A_CMP2_HI: bus_rdata_o = cmp_q[1][CNT_W-1:BUS_W];
      A_CMP2_LO: bus_rdata_o = cmp_q[1][BUS_W-1:0];
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [BUS_W-1:0]  bus_rdata_o,
  input logic [CTL_W-1:0]  ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [N_FLAG-1:0] flag_q,
  input logic [CNT_W-1:0]  cmp1_q
);
  AST_STAT_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == A_STAT) |-> (bus_rdata_o[PAD_W-1:0] == '0)); // R9

  AST_INT_CLK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTL_INT_CLK] |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2

  AST_WRAP_SETS_TOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTL_INT_CLK] && (&cnt_q)) |=> flag_q[FL_TOV]); // R4

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_i || bus_wr_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R8

  AST_ALT_KEEPS_TOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_i || bus_wr_i) && bus_addr_i == A_ALT_LO && flag_q[FL_TOV]) |=> flag_q[FL_TOV]); // R5

  AST_CMP1_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q != $past(cnt_q)) && (cnt_q == cmp1_q) && $stable(cmp1_q)) |-> flag_q[FL_OC1]); // R6
endmodule

bind cct_timer cct_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rdata_o (bus_rdata_o),
  .ctrl_q      (ctrl_q),
  .cnt_q       (cnt_q),
  .flag_q      (flag_q),
  .cmp1_q      (cmp_q[0])
);

// File: tb/cct_timer_tb_top.sv
`timescale 1ns/1ps
module cct_timer_tb_top;
  import cct_pkg::*;

  logic       clk;
  logic       rst_n;
  logic [3:0] addr;
  logic       rd, wr;
  logic [7:0] wdata, rdata;
  logic       ext, cap1, cap2;
  int unsigned cyc;
  int total, bad;
  int cnt_exp;
  int capv [2];

  cct_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_clk_i(ext), .cap1_i(cap1), .cap2_i(cap2)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d, output int unsigned t);
    @(negedge clk); addr = a; rd = 1'b1; #1; d = rdata; t = cyc;
    @(posedge clk); #1; rd = 1'b0;
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] hi_a, output int v);
    logic [7:0] h, l; int unsigned t;
    rd8(hi_a, h, t);
    rd8(hi_a + 4'd1, l, t);
    v = {h, l};
  endtask

  task automatic stat(output int v);
    logic [7:0] s; int unsigned t;
    rd8(A_STAT, s, t);
    v = s;
  endtask

  task automatic touch(input logic [3:0] a);
    logic [7:0] d; int unsigned t;
    rd8(a, d, t);
  endtask

  task automatic drive_pin(input int which, input logic v);
    @(negedge clk);
    case (which)
      0: ext  = v;
      1: cap1 = v;
      default: cap2 = v;
    endcase
    repeat (5) @(posedge clk);
  endtask

  task automatic ext_pulse();
    drive_pin(0, 1'b1);
    drive_pin(0, 1'b0);
    cnt_exp = (cnt_exp + 1) & 16'hFFFF;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, s, c;
    total = 0; bad = 0; cnt_exp = 0; capv[0] = 0; capv[1] = 0;
    rst_n = 1'b0; addr = '0; rd = 0; wr = 0; wdata = '0;
    ext = 0; cap1 = 0; cap2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    stat(s);               chk("R1 status", s, 0);
    rd16(A_ALT_HI, v);     chk("R1 counter", v, 0);
    touch(A_CTRL);
    rd16(A_CAP1_HI, v);    chk("R1 cap1", v, 0);
    rd16(A_CAP2_HI, v);    chk("R1 cap2", v, 0);
    rd16(A_CMP1_HI, v);    chk("R1 cmp1", v, 16'hFFFF);
    rd16(A_CMP2_HI, v);    chk("R1 cmp2", v, 16'hFFFF);
    begin logic [7:0] d; int unsigned t; rd8(A_CTRL, d, t); chk("R1 ctrl", d, 0); end

    // R9 status is read-only
    wr8(A_STAT, 8'hFF);
    stat(s);               chk("R9 status after write", s, 0);

    // R3 external clock edge select sweep
    for (int m = 0; m < 2; m++) begin
      wr8(A_CTRL, 8'(m));
      drive_pin(0, 1'b1); cnt_exp += m;
      rd16(A_ALT_HI, v);  chk("R3 after rising", v, cnt_exp);
      drive_pin(0, 1'b0); cnt_exp += 1 - m;
      rd16(A_ALT_HI, v);  chk("R3 after falling", v, cnt_exp);
      repeat (8) @(posedge clk);
      rd16(A_ALT_HI, v);  chk("R3 static pin", v, cnt_exp);
    end

    // R6 compare 1 sweep over distances
    wr8(A_CTRL, 8'h01);
    for (int k = 1; k <= 4; k++) begin
      stat(s); touch(A_CMP1_LO);
      c = cnt_exp + k;
      wr8(A_CMP1_HI, 8'(c >> 8)); wr8(A_CMP1_LO, 8'(c));
      for (int p = 1; p < k; p++) ext_pulse();
      stat(s);            chk("R6 oc1 before match", (s >> 6) & 1, 0);
      ext_pulse();
      stat(s);            chk("R6 oc1 at match", (s >> 6) & 1, 1);
    end
    // R6 compare 2
    c = cnt_exp + 2;
    wr8(A_CMP2_HI, 8'(c >> 8)); wr8(A_CMP2_LO, 8'(c));
    ext_pulse();
    stat(s);              chk("R6 oc2 before match", (s >> 3) & 1, 0);
    ext_pulse();
    stat(s);              chk("R6 oc2 at match", (s >> 3) & 1, 1);
    touch(A_CMP2_LO);
    stat(s);              chk("R6 oc2 cleared", (s >> 3) & 1, 0);

    // R7 capture channels x edge select
    for (int ch = 0; ch < 2; ch++) begin
      for (int sel = 0; sel < 2; sel++) begin
        int bitpos, hi_a, lo_a;
        bitpos = (ch == 0) ? 7 : 4;
        hi_a   = (ch == 0) ? A_CAP1_HI : A_CAP2_HI;
        lo_a   = hi_a + 1;
        wr8(A_CTRL, 8'(1 | (sel << ((ch == 0) ? 2 : 1))));
        stat(s); touch(4'(lo_a));
        ext_pulse();
        drive_pin(ch + 1, 1'b1);
        if (sel == 1) capv[ch] = cnt_exp;
        rd16(4'(hi_a), v); chk("R7 capture on rise", v, capv[ch]);
        stat(s);           chk("R7 flag on rise", (s >> bitpos) & 1, sel);
        touch(4'(lo_a));
        stat(s);           chk("R7 flag cleared", (s >> bitpos) & 1, 0);
        touch(4'(lo_a));
        ext_pulse();
        drive_pin(ch + 1, 1'b0);
        if (sel == 0) capv[ch] = cnt_exp;
        rd16(4'(hi_a), v); chk("R7 capture on fall", v, capv[ch]);
        stat(s);           chk("R7 flag on fall", (s >> bitpos) & 1, 1 - sel);
        touch(4'(lo_a));
      end
    end

    // R8 per-flag arming: event lands between status read and access
    wr8(A_CTRL, 8'h05);
    stat(s); touch(A_CAP1_LO);
    stat(s);              chk("R8 ic1 clear before window", (s >> 7) & 1, 0);
    drive_pin(1, 1'b1);
    touch(A_CAP1_LO);
    touch(A_CAP1_LO);
    stat(s);              chk("R8 late flag survives access", (s >> 7) & 1, 1);
    touch(A_CAP1_LO);
    stat(s);              chk("R8 armed flag clears", (s >> 7) & 1, 0);
    drive_pin(1, 1'b0);

    // R2 internal clock: low-byte advance equals elapsed cycles
    wr8(A_CTRL, 8'h08);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a1, a2; int unsigned t1, t2;
      rd8(A_ALT_LO, a1, t1);
      repeat (k * 7) @(posedge clk);
      rd8(A_ALT_LO, a2, t2);
      chk("R2 count rate", 8'(a2 - a1), 8'(t2 - t1));
    end

    // R4 overflow after a full wrap
    repeat (70000) @(posedge clk);
    wr8(A_CTRL, 8'h00);
    rd16(A_ALT_HI, c);
    repeat (10) @(posedge clk);
    rd16(A_ALT_HI, v);    chk("R3 frozen count", v, c);

    // R5 clearing sequence for overflow
    wr8(A_CNT_LO, 8'h00);
    stat(s);              chk("R4 tov set, R8 unarmed access kept it", (s >> 5) & 1, 1);
    touch(A_ALT_LO);
    stat(s);              chk("R5 alias read keeps tov", (s >> 5) & 1, 1);
    touch(A_CNT_LO);
    stat(s);              chk("R5 tov cleared", (s >> 5) & 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule